// File: doc/BRIEF.md
# Interrupt Entry State Update Unit

This unit performs the register write-back that happens when the core takes an interrupt. When a take strobe arrives with a valid interrupt identifier, it updates five registers in one clock edge. The first save/restore register receives a return address. The second receives a copy of the status word. The status (machine state) register receives a sanitized copy of that word. The syndrome register records why the interrupt happened. The vector register receives the address that instruction fetch will jump to.

The unit is specialised for the vector-extension floating-point rounding interrupt. For that interrupt, the return address is the instruction after the excepting one, and the syndrome is rewritten. Every other interrupt identifier in range uses the faulting instruction's address and leaves the syndrome alone. The vector address is formed by bit concatenation. It takes the upper half of a prefix register, then a slice of the offset register that belongs to the interrupt, then four zero bits.

Register bits use 32-bit big-endian numbering. Architectural bit 32 maps to `[31]` and bit 63 maps to `[0]`. Pipeline flush and the fetch itself are handled elsewhere. The machine-check syndrome and data address registers are not driven by this unit, so a take leaves them as they were.

Top module: `irq_entry_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all five outputs read zero.
- R2: On a clock edge where `take_i` is low, every output keeps its previous value.
- R3: A take whose identifier equals the rounding-interrupt identifier (default 34) loads `save0_o` with `next_pc_i`.
- R4: A take with any other identifier below `NUM_IRQ` loads `save0_o` with `fault_pc_i`. On such a take, `syn_o` keeps its previous value.
- R5: Every take with an in-range identifier loads `save1_o` with `msr_i` as sampled on that edge.
- R6: Every take with an in-range identifier loads `msr_o` with `msr_i & 32'h0002_1202`. This keeps critical enable `[17]`, machine-check enable `[12]`, debug enable `[9]` and recoverable `[1]`. It clears all other bits, including user cache lock `[26]`, vector enable `[25]`, wait enable `[18]`, external enable `[15]`, problem state `[14]`, float available `[13]`, FE0 `[11]`, FE1 `[8]`, instruction space `[5]` and data space `[4]`.
- R7: A take of the rounding interrupt writes `syn_o` as follows:
  - `32'h80` (vector-extension cause bit `[7]`) when `vle_i` is low.
  - `32'hA0` (bit `[7]` plus the variable-length-encoding bit `[5]`) when `vle_i` is high.
- R8: Every take with an in-range identifier loads `vec_o` with `{prefix_i[31:16], ofs[id][15:4], 4'b0000}`. Here `ofs[id]` is the word `offsets_i[id*32 +: 32]`.
- R9: A take whose identifier is `NUM_IRQ` or larger (default `NUM_IRQ` = 40) changes none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | One-cycle take strobe |
| irq_id_i | input | ID_W (6) | Identifier of the interrupt being taken |
| vle_i | input | 1 | Excepting instruction used variable-length encoding |
| msr_i | input | 32 | Current machine state word |
| fault_pc_i | input | 32 | Address of the excepting instruction |
| next_pc_i | input | 32 | Address of the following instruction |
| prefix_i | input | 32 | Vector prefix register |
| offsets_i | input | NUM_IRQ*32 (1280) | Per-interrupt offset registers, identifier n in bits `[n*32 +: 32]` |
| save0_o | output | 32 | Save/restore register 0 |
| save1_o | output | 32 | Save/restore register 1 |
| msr_o | output | 32 | Machine state register after entry |
| syn_o | output | 32 | Exception syndrome register |
| vec_o | output | 32 | Vector fetch address |

## Verification
On a single take edge, `save1_o` captures the old status word while `msr_o` is overwritten with its masked form. In hardware, the status output feeds back as the next status input. The bench therefore wires `msr_o` back into `msr_i` and issues takes on consecutive cycles. Each `save1_o` is judged against the status value the bench model held before that edge, and never against the one written on the edge. A masking or capture-ordering slip therefore shows up as a mismatch on the second strobe of the pair.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   localparam int XLEN = 32;

   typedef struct packed {
      logic [XLEN-1:0] save0;
      logic [XLEN-1:0] save1;
      logic [XLEN-1:0] msr;
      logic [XLEN-1:0] syn;
      logic [XLEN-1:0] vec;
   } entry_state_t;

   // big-endian architectural bit number (32..63) to [31:0] position
   function automatic int be_pos(input int arch_bit);
      return 63 - arch_bit;
   endfunction
endpackage

// File: rtl/irq_vec_former.sv
module irq_vec_former
   import irq_entry_pkg::*;
#(
   parameter int NUM_IRQ = 40,
   parameter int ID_W    = 6,
   parameter int PFX_W   = 16,
   parameter int ALIGN   = 4
) (
   input  logic [XLEN-1:0]         prefix_i,
   input  logic [NUM_IRQ*XLEN-1:0] offsets_i,
   input  logic [ID_W-1:0]         id_i,
   output logic                    id_ok_o,
   output logic [XLEN-1:0]         vec_o
);
   localparam int SLOTS = 1 << ID_W;
   localparam int OFS_W = XLEN - PFX_W - ALIGN;

   if (NUM_IRQ > SLOTS) begin : g_bad_num
      $error("NUM_IRQ exceeds identifier range");
   end
   if (OFS_W < 1) begin : g_bad_split
      $error("prefix and alignment leave no offset bits");
   end

   logic [XLEN-1:0] ofs_arr [SLOTS];

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < NUM_IRQ) begin : g_live
         assign ofs_arr[i] = offsets_i[i*XLEN +: XLEN];
      end else begin : g_pad
         assign ofs_arr[i] = '0;
      end
   end

   logic [XLEN-1:0] sel_ofs;
   assign sel_ofs = ofs_arr[id_i];
   assign id_ok_o = (32'(id_i) < NUM_IRQ);

   if (ALIGN == 0) begin : g_no_align
      assign vec_o = {prefix_i[XLEN-1 -: PFX_W], sel_ofs[OFS_W-1:0]};
      logic unused_hi;
      assign unused_hi = ^sel_ofs[XLEN-1:OFS_W];
   end else begin : g_align
      assign vec_o = {prefix_i[XLEN-1 -: PFX_W], sel_ofs[OFS_W+ALIGN-1:ALIGN],
                      {ALIGN{1'b0}}};
      logic unused_bits;
      assign unused_bits = ^{sel_ofs[XLEN-1:OFS_W+ALIGN], sel_ofs[ALIGN-1:0]};
   end

   logic unused_pfx;
   assign unused_pfx = ^prefix_i[XLEN-PFX_W-1:0];
endmodule

// File: rtl/irq_state_mask.sv
module irq_state_mask
   import irq_entry_pkg::*;
#(
   parameter logic [XLEN-1:0] KEEP_MASK = 32'h0002_1202,
   parameter int CAUSE_BIT = 56,
   parameter int VLE_BIT   = 58
) (
   input  logic [XLEN-1:0] msr_i,
   input  logic            vle_i,
   output logic [XLEN-1:0] msr_new_o,
   output logic [XLEN-1:0] syn_new_o
);
   localparam int CAUSE_POS = be_pos(CAUSE_BIT);
   localparam int VLE_POS   = be_pos(VLE_BIT);

   if (CAUSE_POS < 0 || CAUSE_POS >= XLEN || VLE_POS < 0 || VLE_POS >= XLEN)
   begin : g_bad_pos
      $error("syndrome bit outside the low word");
   end
   if (CAUSE_POS == VLE_POS) begin : g_same_pos
      $error("syndrome bits collide");
   end

   assign msr_new_o = msr_i & KEEP_MASK;

   always_comb begin
      syn_new_o            = '0;
      syn_new_o[CAUSE_POS] = 1'b1;
      syn_new_o[VLE_POS]   = vle_i;
   end
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
   import irq_entry_pkg::*;
#(
   parameter int NUM_IRQ = 40,
   parameter int ID_W    = 6,
   parameter int RND_ID  = 34,
   parameter logic [XLEN-1:0] KEEP_MASK = 32'h0002_1202
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take_i,
   input  logic [ID_W-1:0]         irq_id_i,
   input  logic                    vle_i,
   input  logic [XLEN-1:0]         msr_i,
   input  logic [XLEN-1:0]         fault_pc_i,
   input  logic [XLEN-1:0]         next_pc_i,
   input  logic [XLEN-1:0]         prefix_i,
   input  logic [NUM_IRQ*XLEN-1:0] offsets_i,
   output logic [XLEN-1:0]         save0_o,
   output logic [XLEN-1:0]         save1_o,
   output logic [XLEN-1:0]         msr_o,
   output logic [XLEN-1:0]         syn_o,
   output logic [XLEN-1:0]         vec_o
);
   if (RND_ID >= NUM_IRQ) begin : g_bad_rnd
      $error("rounding identifier outside NUM_IRQ");
   end

   logic            id_ok;
   logic [XLEN-1:0] vec_new, msr_new, syn_new;

   irq_vec_former #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) vec_i (
      .prefix_i (prefix_i),
      .offsets_i(offsets_i),
      .id_i     (irq_id_i),
      .id_ok_o  (id_ok),
      .vec_o    (vec_new)
   );

   irq_state_mask #(.KEEP_MASK(KEEP_MASK)) mask_i (
      .msr_i    (msr_i),
      .vle_i    (vle_i),
      .msr_new_o(msr_new),
      .syn_new_o(syn_new)
   );

   logic         is_rnd, do_take;
   entry_state_t cur_q, nxt;

   assign is_rnd  = (32'(irq_id_i) == RND_ID);
   assign do_take = take_i && id_ok;

   always_comb begin
      nxt = cur_q;
      if (do_take) begin
         nxt.save0 = is_rnd ? next_pc_i : fault_pc_i;
         nxt.save1 = msr_i;
         nxt.msr   = msr_new;
         nxt.vec   = vec_new;
         if (is_rnd) nxt.syn = syn_new;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cur_q <= '0;
      else        cur_q <= nxt;
   end

   assign save0_o = cur_q.save0;
   assign save1_o = cur_q.save1;
   assign msr_o   = cur_q.msr;
   assign syn_o   = cur_q.syn;
   assign vec_o   = cur_q.vec;

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> $stable(cur_q));
   // R9
   bad_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && 32'(irq_id_i) >= NUM_IRQ) |=> $stable(cur_q));
   // R5
   save1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_take |=> save1_o == $past(msr_i));
   // R6
   msr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_take |=> (msr_o & ~KEEP_MASK) == '0);
   // R8
   vec_pfx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_take |=> vec_o[31:16] == $past(prefix_i[31:16]) && vec_o[3:0] == 4'h0);
   // R3
   rnd_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_take && is_rnd) |=> save0_o == $past(next_pc_i));
   // R4
   other_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_take && !is_rnd) |=> $stable(syn_o));
endmodule

// File: tb/irq_entry_unit_tb_top.sv
module irq_entry_unit_tb_top;
   localparam int N  = 40;
   localparam int RN = 34;
   localparam logic [31:0] KEEP = 32'h0002_1202;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          take = 1'b0;
   logic [5:0]    id = '0;
   logic          vle = 1'b0;
   logic [31:0]   msr_drv = '0, fpc = '0, npc = '0, pfx = '0;
   logic          loop_msr = 1'b0;
   logic [31:0]   msr_in;
   logic [N*32-1:0] ofs;
   logic [31:0]   s0, s1, m, sy, v;

   int errs = 0, checks = 0;
   logic [31:0] e_s0 = '0, e_s1 = '0, e_m = '0, e_sy = '0, e_v = '0;

   always #2 clk = ~clk;

   assign msr_in = loop_msr ? m : msr_drv;

   irq_entry_unit dut_i (
      .clk(clk), .rst_n(rst_n), .take_i(take), .irq_id_i(id), .vle_i(vle),
      .msr_i(msr_in), .fault_pc_i(fpc), .next_pc_i(npc), .prefix_i(pfx),
      .offsets_i(ofs), .save0_o(s0), .save1_o(s1), .msr_o(m), .syn_o(sy),
      .vec_o(v)
   );

   task automatic chk(input string r, input logic [31:0] act, exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic check_all(input string r);
      chk({r, " R3/R4 save0"}, s0, e_s0);
      chk({r, " R5 save1"}, s1, e_s1);
      chk({r, " R6 msr"}, m, e_m);
      chk({r, " R7 syn"}, sy, e_sy);
      chk({r, " R8 vec"}, v, e_v);
   endtask

   // drive at negedge, model update, sample at following negedge
   task automatic take_one(input int i, input logic [31:0] ms, input logic vl);
      logic [31:0] o, mcur;
      id = 6'(i); vle = vl; msr_drv = ms;
      fpc = 32'h1000_0000 + 32'(i) * 4; npc = fpc + 4;
      pfx = 32'hA5C3_0000 ^ (32'(i) << 18) ^ 32'h0000_FFFF;
      take = 1'b1;
      mcur = loop_msr ? e_m : ms;
      if (i < N) begin
         o    = ofs[i*32 +: 32];
         e_s0 = (i == RN) ? npc : fpc;
         e_s1 = mcur;
         e_m  = mcur & KEEP;
         e_v  = {pfx[31:16], o[15:4], 4'h0};
         if (i == RN) e_sy = 32'h80 | (vl ? 32'h20 : 32'h0);
      end
      @(negedge clk);
      take = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < N; i++)
         ofs[i*32 +: 32] = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
      @(negedge clk); @(negedge clk);
      check_all("R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after reset");

      // rounding interrupt, both encodings, several status words
      take_one(RN, 32'hFFFF_FFFF, 1'b0); check_all("R3 R7 rnd all-ones");
      take_one(RN, 32'h0602_7A31, 1'b1); check_all("R3 R7 rnd vle");
      take_one(RN, 32'h0000_0000, 1'b1); check_all("R7 rnd zero msr");
      // R2: idle cycles with changing inputs
      msr_drv = 32'h1234_5678; pfx = 32'hFFFF_FFFF; fpc = 32'hDEAD_BEEF;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); check_all("R2 idle");
      end

      // sweep every identifier (R4, R5, R6, R8, R9)
      for (int i = 0; i < 64; i++) begin
         take_one(i, (32'(i) * 32'h0101_0101) ^ 32'h3C3C_F00F, i[0]);
         check_all((i >= N) ? "R9 out-of-range id" : "R4 sweep id");
      end

      // status fed back: save1 must hold the pre-entry word (R5 R6)
      take_one(3, 32'hFFFF_FFFF, 1'b0);
      loop_msr = 1'b1;
      take_one(RN, 32'h0, 1'b1); check_all("R5 chained first");
      take_one(7, 32'h0, 1'b0);  check_all("R5 chained second");
      take_one(50, 32'h0, 1'b0); check_all("R9 chained bad id");
      loop_msr = 1'b0;

      rst_n = 1'b0;
      e_s0 = '0; e_s1 = '0; e_m = '0; e_sy = '0; e_v = '0;
      @(negedge clk); check_all("R1 re-reset");

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule